// File: doc/BRIEF.md
# BCD Time-of-Day Register File

This block keeps a calendar as a set of separate 4-bit decimal digits. Each digit has its own word-aligned address. The digits are tenths of seconds, units and tens of seconds, minutes, hours, day of the month and month, plus a day-of-week counter and a one-hot position within the four-year leap cycle. Software reads each digit directly and writes each digit from the low nibble of the write data.

A single-cycle `tick` pulse advances the time by one tenth of a second. The carries ripple in decimal all the way from tenths to the leap-cycle position. A run bit in a control word gates the counting. Software clears the run bit, loads the digits one at a time without the clock moving underneath it, and then sets the run bit to commit the loaded time and resume counting from it.

Reads are combinational from the address. Writes take effect at the clock edge.

Top module: `bcd_tod_regfile`

## Requirements
- R1: After reset the digits hold 00:00:00.0 on day 01 of month 01. Day of week reads 1, the year stage reads 1 (0001) and the run bit reads 0.
- R2: Byte offsets map to digits as follows: 0x04 tenths, 0x08/0x0C seconds units/tens, 0x10/0x14 minutes units/tens, 0x18/0x1C hours units/tens, 0x20/0x24 day units/tens, 0x28 day of week, 0x2C/0x30 month units/tens, 0x34 year stage. A write stores wdata[3:0] and ignores the upper bits. A read returns the digit in rdata[3:0] with the upper bits zero.
- R3: Any offset that is not one of the thirteen digit offsets or 0x38 reads as zero. This includes 0x00, 0x3C and every offset whose two low bits are not 00. A write to such an offset changes no digit and does not change the run bit.
- R4: Offset 0x38 is the control word, and its bit 0 is the run bit. Writing 1 commits the loaded time and enables counting. Writing 0 halts counting. A read returns the run bit in bit 0. While the run bit is 0, tick pulses leave every digit unchanged.
- R5: While running, each tick advances tenths through 0–9. Seconds count 00–59 and minutes count 00–59, each with a decimal carry into the next digit.
- R6: Hours count 00–23. On the tick after 23:59:59.9 the hours go to 00 and the day advances.
- R7: Day of week advances by one at each day rollover and wraps from 7 to 1.
- R8: After the last day of the month, the day goes to 01 and the month advances. The last day is 30 for months 04, 06, 09 and 11, and 31 for the other months except February. February ends on day 28, or on day 29 when the year stage is 8 (leap year).
- R9: After December 31, the month goes to 01 and the year stage rotates left one place: 1→2→4→8→1. The stage values 1, 2, 4 and 8 mean three, two, one and zero years before a leap year.
- R10: In a cycle where wr_en is high, the tick is dropped. The write lands and no digit advances in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse that advances the time by a tenth of a second |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (6) | Byte offset of the addressed word |
| wdata | input | DATA_W (8) | Write data; digits take bits [3:0], control takes bit 0 |
| rdata | output | DATA_W (8) | Combinational read data for addr |

## Verification
The bench builds the block with the default ADDR_W of 6 and DATA_W of 8. With a 6-bit address the bench can also reach offsets above the control word, such as 0x3C, as well as misaligned offsets. That lets it confirm that the decoder rejects them for both reads and writes. With an 8-bit data path, the bench can set upper bits on digit writes and confirm that those bits are dropped and that they read back as zero. Every carry boundary is reached by loading the digits directly, from a tenth-second step up to a December-to-January rollover that moves the leap-cycle position.

// File: rtl/bcd_tod_pkg.sv
`timescale 1ns/1ps
package bcd_tod_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 13;
    localparam int SLOT_W     = $clog2(NUM_DIGITS);
    localparam int CTRL_WORD  = NUM_DIGITS + 1;   // word index of the run control

    // Slot order follows the word addresses: slot n lives at byte offset 4*(n+1)
    localparam int SLOT_TENTHS = 0;
    localparam int SLOT_SEC_U  = 1;
    localparam int SLOT_SEC_T  = 2;
    localparam int SLOT_MIN_U  = 3;
    localparam int SLOT_MIN_T  = 4;
    localparam int SLOT_HR_U   = 5;
    localparam int SLOT_HR_T   = 6;
    localparam int SLOT_DAY_U  = 7;
    localparam int SLOT_DAY_T  = 8;
    localparam int SLOT_DOW    = 9;
    localparam int SLOT_MON_U  = 10;
    localparam int SLOT_MON_T  = 11;
    localparam int SLOT_YEAR   = 12;

    typedef logic [DIGIT_W-1:0] digit_t;
    typedef digit_t [NUM_DIGITS-1:0] tod_regs_t;

    typedef struct packed {
        digit_t tens;
        digit_t units;
    } bcd_pair_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_DIGIT = 2'd1,
        SEL_CTRL  = 2'd2
    } sel_kind_e;

    localparam digit_t STAGE_LEAP = 4'd8;
    localparam digit_t DIGIT_NINE = 4'd9;
    localparam digit_t DIGIT_FIVE = 4'd5;

    // 00:00:00.0, day 01, month 01, weekday 1, stage 1
    localparam tod_regs_t TOD_RESET = 52'h1_0_1_1_0_1_0_0_0_0_0_0_0;

    // One decimal digit step: returns {wrap, next}
    function automatic logic [DIGIT_W:0] count_digit(digit_t d, digit_t top);
        if (d >= top) return {1'b1, digit_t'(0)};
        return {1'b0, d + digit_t'(1)};
    endfunction

    // Last day of the month, in BCD, for a BCD month and a leap-cycle stage
    function automatic bcd_pair_t month_last_day(bcd_pair_t mon, digit_t stage);
        case (mon)
            8'h02:                      return (stage == STAGE_LEAP) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic digit_t rotate_stage(digit_t s);
        return {s[DIGIT_W-2:0], s[DIGIT_W-1]};
    endfunction

endpackage

// File: rtl/tod_addr_decode.sv
`timescale 1ns/1ps
module tod_addr_decode
    import bcd_tod_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output sel_kind_e         kind,
    output logic [SLOT_W-1:0] slot
);
    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word;
    assign word = addr[ADDR_W-1:2];

    always_comb begin
        kind = SEL_NONE;
        slot = '0;
        if (addr[1:0] == 2'b00) begin
            if (int'(word) >= 1 && int'(word) <= NUM_DIGITS) begin
                kind = SEL_DIGIT;
                slot = SLOT_W'(int'(word) - 1);
            end else if (int'(word) == CTRL_WORD) begin
                kind = SEL_CTRL;
            end
        end
    end
endmodule

// File: rtl/tod_calendar_step.sv
`timescale 1ns/1ps
module tod_calendar_step
    import bcd_tod_pkg::*;
(
    input  tod_regs_t cur,
    output tod_regs_t nxt
);
    logic [DIGIT_W:0] stp;
    logic c_sec, c_10s, c_min, c_10m, c_hr, c_day, c_mon;
    bcd_pair_t last_day, day_now, mon_now, hr_now;

    always_comb begin
        nxt      = cur;
        c_sec    = 1'b0;
        c_10s    = 1'b0;
        c_min    = 1'b0;
        c_10m    = 1'b0;
        c_hr     = 1'b0;
        c_day    = 1'b0;
        c_mon    = 1'b0;
        hr_now   = {cur[SLOT_HR_T],  cur[SLOT_HR_U]};
        day_now  = {cur[SLOT_DAY_T], cur[SLOT_DAY_U]};
        mon_now  = {cur[SLOT_MON_T], cur[SLOT_MON_U]};
        last_day = month_last_day(mon_now, cur[SLOT_YEAR]);

        // tenths, seconds, minutes
        stp = count_digit(cur[SLOT_TENTHS], DIGIT_NINE);
        nxt[SLOT_TENTHS] = stp[DIGIT_W-1:0];
        c_sec = stp[DIGIT_W];
        if (c_sec) begin
            stp = count_digit(cur[SLOT_SEC_U], DIGIT_NINE);
            nxt[SLOT_SEC_U] = stp[DIGIT_W-1:0];
            c_10s = stp[DIGIT_W];
        end
        if (c_10s) begin
            stp = count_digit(cur[SLOT_SEC_T], DIGIT_FIVE);
            nxt[SLOT_SEC_T] = stp[DIGIT_W-1:0];
            c_min = stp[DIGIT_W];
        end
        if (c_min) begin
            stp = count_digit(cur[SLOT_MIN_U], DIGIT_NINE);
            nxt[SLOT_MIN_U] = stp[DIGIT_W-1:0];
            c_10m = stp[DIGIT_W];
        end
        if (c_10m) begin
            stp = count_digit(cur[SLOT_MIN_T], DIGIT_FIVE);
            nxt[SLOT_MIN_T] = stp[DIGIT_W-1:0];
            c_hr = stp[DIGIT_W];
        end

        // hours 00-23
        if (c_hr) begin
            if (hr_now >= 8'h23) begin
                nxt[SLOT_HR_U] = '0;
                nxt[SLOT_HR_T] = '0;
                c_day = 1'b1;
            end else begin
                stp = count_digit(cur[SLOT_HR_U], DIGIT_NINE);
                nxt[SLOT_HR_U] = stp[DIGIT_W-1:0];
                if (stp[DIGIT_W]) nxt[SLOT_HR_T] = cur[SLOT_HR_T] + digit_t'(1);
            end
        end

        // weekday and day of month
        if (c_day) begin
            nxt[SLOT_DOW] = (cur[SLOT_DOW] >= 4'd7) ? 4'd1 : cur[SLOT_DOW] + digit_t'(1);
            if (day_now >= last_day) begin
                nxt[SLOT_DAY_T] = 4'd0;
                nxt[SLOT_DAY_U] = 4'd1;
                c_mon = 1'b1;
            end else begin
                stp = count_digit(cur[SLOT_DAY_U], DIGIT_NINE);
                nxt[SLOT_DAY_U] = stp[DIGIT_W-1:0];
                if (stp[DIGIT_W]) nxt[SLOT_DAY_T] = cur[SLOT_DAY_T] + digit_t'(1);
            end
        end

        // month 01-12, then the leap-cycle stage
        if (c_mon) begin
            if (mon_now >= 8'h12) begin
                nxt[SLOT_MON_T] = 4'd0;
                nxt[SLOT_MON_U] = 4'd1;
                nxt[SLOT_YEAR]  = rotate_stage(cur[SLOT_YEAR]);
            end else begin
                stp = count_digit(cur[SLOT_MON_U], DIGIT_NINE);
                nxt[SLOT_MON_U] = stp[DIGIT_W-1:0];
                if (stp[DIGIT_W]) nxt[SLOT_MON_T] = cur[SLOT_MON_T] + digit_t'(1);
            end
        end
    end
endmodule

// File: rtl/bcd_tod_regfile.sv
`timescale 1ns/1ps
module bcd_tod_regfile
    import bcd_tod_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    sel_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    tod_regs_t         regs, regs_next;
    logic              run_q;
    logic              advance;

    tod_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (addr),
        .kind (kind),
        .slot (slot)
    );

    tod_calendar_step u_step (
        .cur (regs),
        .nxt (regs_next)
    );

    // A write cycle always drops the tick
    assign advance = run_q && tick && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs  <= TOD_RESET;
            run_q <= 1'b0;
        end else if (wr_en) begin
            if (kind == SEL_CTRL) run_q <= wdata[0];
            for (int i = 0; i < NUM_DIGITS; i++) begin
                if (kind == SEL_DIGIT && int'(slot) == i) regs[i] <= wdata[DIGIT_W-1:0];
            end
        end else if (advance) begin
            regs <= regs_next;
        end
    end

    always_comb begin
        rdata = '0;
        case (kind)
            SEL_DIGIT: rdata = DATA_W'(regs[slot]);
            SEL_CTRL:  rdata = DATA_W'(run_q);
            default:   rdata = '0;
        endcase
    end

    // Halted with no write: nothing moves (R4)
    assert_halt_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !wr_en) |=> $stable(regs));

    // Misaligned offsets always read zero (R3)
    assert_misaligned_reads_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (addr[1:0] != 2'b00) |-> (rdata == '0));

    // A write to a non-digit word, even with a tick, leaves all digits alone (R3, R10)
    assert_nondigit_write_keeps_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && kind != SEL_DIGIT) |=> $stable(regs));

    // Tenths wrap to zero (R5)
    assert_tenths_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && regs[SLOT_TENTHS] == 4'd9) |=> (regs[SLOT_TENTHS] == 4'd0));

    // Hours stay in 00-23 once they are legal (R6)
    assert_hour_range_R6: assert property (@(posedge clk) disable iff (rst)
        (advance && {regs[SLOT_HR_T], regs[SLOT_HR_U]} <= 8'h23)
        |=> ({regs[SLOT_HR_T], regs[SLOT_HR_U]} <= 8'h23));

    // Weekday stays in 1-7 (R7)
    assert_dow_range_R7: assert property (@(posedge clk) disable iff (rst)
        (advance && regs[SLOT_DOW] >= 4'd1 && regs[SLOT_DOW] <= 4'd7)
        |=> (regs[SLOT_DOW] >= 4'd1 && regs[SLOT_DOW] <= 4'd7));

    // Leap-cycle stage stays one-hot under counting (R9)
    assert_stage_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        (advance && $onehot(regs[SLOT_YEAR])) |=> $onehot(regs[SLOT_YEAR]));
endmodule

// File: tb/bcd_tod_regfile_test.sv
`timescale 1ns/1ps
module bcd_tod_regfile_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bcd_tod_regfile uut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Hex digits, MSB first: year, mon_t, mon_u, dow, day_t, day_u,
    // hr_t, hr_u, min_t, min_u, sec_t, sec_u, tenths
    localparam int NV = 19;
    localparam logic [51:0] VIN [NV] = '{
        52'h1_0_1_3_1_5_1_0_2_0_3_0_5,  // R5 tenths step
        52'h1_0_1_3_1_5_1_0_2_0_3_0_9,  // R5 tenths into seconds
        52'h1_0_1_3_1_5_1_0_2_0_5_9_9,  // R5 seconds into minutes
        52'h1_0_1_3_1_5_0_9_5_9_5_9_9,  // R5 minutes into hours 09->10
        52'h1_0_1_3_1_5_2_3_5_9_5_9_9,  // R6 midnight
        52'h1_0_1_3_1_5_1_9_5_9_5_9_9,  // R6 19->20
        52'h1_0_1_7_0_9_2_3_5_9_5_9_9,  // R7 weekday 7->1, day 09->10
        52'h1_0_1_2_3_1_2_3_5_9_5_9_9,  // R8 Jan 31
        52'h1_0_4_2_3_0_2_3_5_9_5_9_9,  // R8 Apr 30
        52'h1_0_4_2_2_9_2_3_5_9_5_9_9,  // R8 Apr 29
        52'h4_0_2_5_2_8_2_3_5_9_5_9_9,  // R8 Feb 28 non-leap
        52'h8_0_2_5_2_8_2_3_5_9_5_9_9,  // R8 Feb 28 leap
        52'h8_0_2_6_2_9_2_3_5_9_5_9_9,  // R8 Feb 29 leap
        52'h2_0_9_1_3_0_2_3_5_9_5_9_9,  // R8 Sep 30
        52'h2_1_0_5_3_1_2_3_5_9_5_9_9,  // R8 Oct 31
        52'h2_1_1_3_3_0_2_3_5_9_5_9_9,  // R8 Nov 30
        52'h8_1_2_5_3_1_2_3_5_9_5_9_9,  // R9 Dec 31 leap -> stage 1
        52'h2_1_2_7_3_1_2_3_5_9_5_9_9,  // R9 Dec 31 stage 2 -> 4
        52'h2_1_2_1_3_0_2_3_5_9_5_9_9   // R8 Dec 30
    };
    localparam logic [51:0] VEXP [NV] = '{
        52'h1_0_1_3_1_5_1_0_2_0_3_0_6,
        52'h1_0_1_3_1_5_1_0_2_0_3_1_0,
        52'h1_0_1_3_1_5_1_0_2_1_0_0_0,
        52'h1_0_1_3_1_5_1_0_0_0_0_0_0,
        52'h1_0_1_4_1_6_0_0_0_0_0_0_0,
        52'h1_0_1_3_1_5_2_0_0_0_0_0_0,
        52'h1_0_1_1_1_0_0_0_0_0_0_0_0,
        52'h1_0_2_3_0_1_0_0_0_0_0_0_0,
        52'h1_0_5_3_0_1_0_0_0_0_0_0_0,
        52'h1_0_4_3_3_0_0_0_0_0_0_0_0,
        52'h4_0_3_6_0_1_0_0_0_0_0_0_0,
        52'h8_0_2_6_2_9_0_0_0_0_0_0_0,
        52'h8_0_3_7_0_1_0_0_0_0_0_0_0,
        52'h2_1_0_2_0_1_0_0_0_0_0_0_0,
        52'h2_1_1_6_0_1_0_0_0_0_0_0_0,
        52'h2_1_2_4_0_1_0_0_0_0_0_0_0,
        52'h1_0_1_6_0_1_0_0_0_0_0_0_0,
        52'h4_0_1_1_0_1_0_0_0_0_0_0_0,
        52'h2_1_2_2_3_1_0_0_0_0_0_0_0
    };
    localparam int VREQ [NV] = '{5,5,5,5,6,6,7,8,8,8,8,8,8,8,8,8,9,9,8};

    task automatic check(input string req, input logic [51:0] act, input logic [51:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic load_all(input logic [51:0] v);
        for (int i = 0; i < 13; i++) wr(6'((i + 1) * 4), {4'h0, v[i*4 +: 4]});
    endtask

    task automatic read_all(output logic [51:0] v);
        logic [7:0] d;
        for (int i = 0; i < 13; i++) begin
            rd(6'((i + 1) * 4), d);
            v[i*4 +: 4] = d[3:0];
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic [51:0] got;
        logic [7:0]  b;
        logic [51:0] snap;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        read_all(got);
        check("R1 digits", got, 52'h1_0_1_1_0_1_0_0_0_0_0_0_0);
        rd(6'h38, b);
        check("R1 run bit", {44'h0, b}, 52'h0);

        // Vector table: load halted, commit, one tick, halt, read back
        for (int k = 0; k < NV; k++) begin
            wr(6'h38, 8'h00);
            load_all(VIN[k]);
            wr(6'h38, 8'h01);
            pulse_tick();
            wr(6'h38, 8'h00);
            read_all(got);
            check($sformatf("R%0d vector %0d", VREQ[k], k), got, VEXP[k]);
        end

        // R2: upper write bits dropped, upper read bits zero
        wr(6'h04, 8'hA7);
        rd(6'h04, b);
        check("R2 nibble only", {44'h0, b}, 52'h07);

        // R4: halted ticks ignored; control readback
        load_all(52'h1_0_1_3_1_5_1_0_2_0_3_0_5);
        repeat (3) pulse_tick();
        read_all(got);
        check("R4 halted ticks", got, 52'h1_0_1_3_1_5_1_0_2_0_3_0_5);
        wr(6'h38, 8'h01);
        rd(6'h38, b);
        check("R4 run readback set", {44'h0, b}, 52'h01);
        wr(6'h38, 8'hFE);
        rd(6'h38, b);
        check("R4 run readback clear", {44'h0, b}, 52'h00);

        // R3: unmapped reads zero, unmapped writes inert (incl. misaligned bit-0 write)
        rd(6'h00, b);  check("R3 read 0x00", {44'h0, b}, 52'h0);
        rd(6'h3C, b);  check("R3 read 0x3C", {44'h0, b}, 52'h0);
        rd(6'h06, b);  check("R3 read 0x06", {44'h0, b}, 52'h0);
        rd(6'h39, b);  check("R3 read 0x39", {44'h0, b}, 52'h0);
        snap = 52'h1_0_1_3_1_5_1_0_2_0_3_0_5;
        wr(6'h00, 8'h05);
        wr(6'h3C, 8'h05);
        wr(6'h05, 8'h03);
        wr(6'h39, 8'h01);
        pulse_tick();
        read_all(got);
        check("R3 unmapped writes inert", got, snap);
        rd(6'h38, b);
        check("R3 run untouched", {44'h0, b}, 52'h0);

        // R10: write and tick in the same cycle
        wr(6'h38, 8'h01);
        @(negedge clk);
        addr = 6'h04; wdata = 8'h02; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        wr(6'h38, 8'h00);
        read_all(got);
        check("R10 write wins over tick", got, 52'h1_0_1_3_1_5_1_0_2_0_3_0_2);

        // R5: running again, tick alone advances from the written value
        wr(6'h38, 8'h01);
        pulse_tick();
        wr(6'h38, 8'h00);
        rd(6'h04, b);
        check("R5 advance after write", {44'h0, b}, 52'h03);

        // R1: reset mid-run restores defaults
        wr(6'h38, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_all(got);
        check("R1 reset again", got, 52'h1_0_1_1_0_1_0_0_0_0_0_0_0);
        rd(6'h38, b);
        check("R1 run cleared", {44'h0, b}, 52'h0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule